// File: doc/BRIEF.md
# Input Current Limit Optimizer

This controller finds the largest input current limit that an unknown supply can carry before the input voltage regulation loop has to step in. Once it is enabled, a search starts when a dedicated charging port is detected, or when the force strobe is given, or when any of several restart events occurs. During a search the controller moves a working limit in fixed steps. After each step it waits a programmable number of clock cycles for the supply to settle, then samples a digital flag that is high while input voltage regulation is active.

The search direction depends on the battery. With the battery above the minimum system voltage, the search starts low and climbs. The first step that makes regulation engage is taken back, and the search ends. With the battery below that voltage, the search starts at the programmed limit and descends. It ends at the first step at which regulation is no longer active. The effective limit output carries the search result while the optimizer is active, and the programmed value otherwise. An optional external clamp bounds that output. A two-bit status field reports the search state, and a completion flag stays high until software reads it.

Currents are coded in 10 mA units. At the default parameters a step is 5 codes (50 mA), an upward search starts at code 50 (500 mA), the floor is code 10 and the ceiling is code 330.

Top module: `ico_ctrl`

## Requirements
- R1: After reset, ico_status is 00, ico_done is 0 and eff_lim equals prog_lim (clamped as in R12).
- R2: While ico_en is 0, every trigger input is ignored: ico_status stays 00 and eff_lim stays at prog_lim.
- R3: While ico_en is 1, a one-cycle pulse on src_dcp or on force_set starts a search. ico_status reads 01 after the next rising clock edge.
- R4: With batt_above_min high when a search starts, the working limit begins at code 50 and rises 5 codes per step while vreg_active is low. The first step that samples vreg_active high drops back 5 codes and ends the search. If regulation is already active at code 50, the limit stays at 50.
- R5: An upward search never exceeds code 330. The step that would pass it ends the search instead, at the current value.
- R6: With batt_above_min low when a search starts, the working limit begins at prog_lim and falls 5 codes per step while vreg_active is high. It ends at the first sample with vreg_active low. A step that would go below code 10 ends the search at the current value instead.
- R7: After the search starts or steps, the limit holds for settle_cnt cycles. vreg_active is sampled at the next edge, so the following step appears settle_cnt+1 edges after the previous one.
- R8: When the search ends, ico_status becomes 10 and ico_done goes to 1 at the same edge. The limit then holds whatever vreg_active does.
- R9: A one-cycle pulse on flag_rd clears ico_done.
- R10: While ico_en is 1, each of the following restarts the search with ico_status back to 01: a pulse on src_attach, ilim_wr, vlim_wr, bus_ovp or force_set, or any change of level on hiz_bit.
- R11: eff_lim carries the working limit while ico_en is 1 and ico_status is not 00. Otherwise it carries prog_lim.
- R12: With ext_lim_en at 1, eff_lim is the smaller of the R11 value and ext_lim. With ext_lim_en at 0, no clamp applies.
- R13: Clearing ico_en during a search or after it returns ico_status to 00 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ico_en | input | 1 | Optimizer enable |
| src_dcp | input | 1 | Pulse: dedicated charging port detected |
| force_set | input | 1 | Pulse: force a search |
| src_attach | input | 1 | Pulse: new source attached |
| hiz_bit | input | 1 | High-impedance control level; any change restarts |
| ilim_wr | input | 1 | Pulse: current-limit register written |
| vlim_wr | input | 1 | Pulse: voltage-limit register written |
| bus_ovp | input | 1 | Pulse: bus overvoltage event |
| prog_lim | input | 9 | Programmed current limit, 10 mA per code |
| ext_lim | input | 9 | External clamp limit, 10 mA per code |
| ext_lim_en | input | 1 | Enables the external clamp |
| batt_above_min | input | 1 | Battery above minimum system voltage |
| vreg_active | input | 1 | Input voltage regulation is active |
| settle_cnt | input | 8 | Settle cycles after each step |
| flag_rd | input | 1 | Pulse: completion flag read |
| eff_lim | output | 9 | Effective input current limit |
| ico_status | output | 2 | 00 idle or disabled, 01 searching, 10 optimum found |
| ico_done | output | 1 | Completion flag |

## Verification
A wrong search state or working limit shows up on eff_lim. The cause may be a miscounted settle window, a wrong direction or an off-by-one stop. In each case eff_lim steps one edge early or late, or it settles on a code other than the one the supply model predicts. The per-clock comparison therefore catches the error within one settle window. A restart that the trigger logic misses, or a stale state after disable, shows up on ico_status at the edge after the event. A completion flag that is set too early or too late differs from the model in the same cycle that the status turns to 10.

// File: rtl/ico_pkg.sv
package ico_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_SRCH = 2'b01,
      ST_DONE = 2'b10
   } ico_st_e;
endpackage

// File: rtl/ico_trigger.sv
module ico_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic src_dcp,
   input  logic force_set,
   input  logic src_attach,
   input  logic hiz_bit,
   input  logic ilim_wr,
   input  logic vlim_wr,
   input  logic bus_ovp,
   output logic restart
);
   logic hiz_q;
   logic hiz_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hiz_q <= 1'b0;
      else        hiz_q <= hiz_bit;
   end

   assign hiz_chg = hiz_bit ^ hiz_q;
   assign restart = en & (src_dcp | force_set | src_attach | hiz_chg |
                          ilim_wr | vlim_wr | bus_ovp);

   // R2: no restart is raised while disabled
   p_no_restart_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !restart);
endmodule

// File: rtl/ico_search.sv
module ico_search
   import ico_pkg::*;
#(
   parameter int LIM_W    = 9,
   parameter int CNT_W    = 8,
   parameter int STEP     = 5,
   parameter int START_UP = 50,
   parameter int LIM_MIN  = 10,
   parameter int LIM_MAX  = 330
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  logic             batt_above,
   input  logic             vreg,
   input  logic [LIM_W-1:0] prog_lim,
   input  logic [CNT_W-1:0] settle,
   output ico_st_e          state,
   output logic [LIM_W-1:0] cur_lim,
   output logic             done_now
);
   localparam logic [LIM_W-1:0] STEP_V  = LIM_W'(STEP);
   localparam logic [LIM_W-1:0] START_V = LIM_W'(START_UP);
   localparam logic [LIM_W-1:0] TOP_V   = LIM_W'(LIM_MAX - STEP);
   localparam logic [LIM_W-1:0] LOW_V   = LIM_W'(LIM_MIN + STEP);

   generate
      if (STEP < 1 || LIM_MAX >= (1 << LIM_W))
         $error("ico_search: bad STEP or LIM_MAX for LIM_W");
      if (START_UP < LIM_MIN || START_UP + STEP > LIM_MAX)
         $error("ico_search: START_UP must lie inside the search range");
   endgenerate

   logic             dir_up;
   logic [CNT_W-1:0] cnt;
   logic             sample;
   logic             at_edge;

   assign sample   = en && !restart && (state == ST_SRCH) && (cnt == '0);
   assign at_edge  = dir_up ? (cur_lim > TOP_V) : (cur_lim < LOW_V);
   assign done_now = sample && ((dir_up ? vreg : !vreg) || at_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_lim <= '0;
         cnt     <= '0;
         dir_up  <= 1'b0;
      end else if (!en) begin
         state <= ST_IDLE;
      end else if (restart) begin
         state   <= ST_SRCH;
         dir_up  <= batt_above;
         cur_lim <= batt_above ? START_V : prog_lim;
         cnt     <= settle;
      end else if (state == ST_SRCH) begin
         if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end else if (done_now) begin
            state <= ST_DONE;
            if (dir_up && vreg && cur_lim > START_V)
               cur_lim <= cur_lim - STEP_V;
         end else begin
            cur_lim <= dir_up ? cur_lim + STEP_V : cur_lim - STEP_V;
            cnt     <= settle;
         end
      end
   end

   // R4 R6: inside one search the limit moves by one step at most per edge
   p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SRCH && $past(state) == ST_SRCH && !$past(restart) && $past(en))
      |-> (cur_lim == $past(cur_lim) ||
           {1'b0, cur_lim} == {1'b0, $past(cur_lim)} + {1'b0, STEP_V} ||
           {1'b0, cur_lim} + {1'b0, STEP_V} == {1'b0, $past(cur_lim)}));
   // R5: an upward search stays inside its range
   p_up_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && dir_up) |-> (cur_lim >= START_V && cur_lim <= LIM_W'(LIM_MAX)));
   // R8: the result holds once found
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && $past(state) == ST_DONE) |-> $stable(cur_lim));
   // R7: no step before the settle window has run out
   p_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_SRCH && state == ST_SRCH && $past(cnt) != '0 && !$past(restart))
      |-> $stable(cur_lim));
endmodule

// File: rtl/ico_limit_out.sv
module ico_limit_out #(
   parameter int LIM_W     = 9,
   parameter bit HAS_CLAMP = 1'b1
) (
   input  logic             use_cur,
   input  logic [LIM_W-1:0] cur_lim,
   input  logic [LIM_W-1:0] prog_lim,
   input  logic [LIM_W-1:0] ext_lim,
   input  logic             ext_en,
   output logic [LIM_W-1:0] eff_lim
);
   logic [LIM_W-1:0] base;
   assign base = use_cur ? cur_lim : prog_lim;

   generate
      if (HAS_CLAMP) begin : g_clamp
         assign eff_lim = (ext_en && ext_lim < base) ? ext_lim : base;
         // R12: the clamp bounds the output
         always_comb begin
            p_clamp_r12: assert (!ext_en || eff_lim <= ext_lim);
         end
      end else begin : g_noclamp
         logic unused_ext;
         assign unused_ext = ^{ext_lim, ext_en};
         assign eff_lim    = base;
      end
   endgenerate
endmodule

// File: rtl/ico_ctrl.sv
module ico_ctrl
   import ico_pkg::*;
#(
   parameter int LIM_W     = 9,
   parameter int CNT_W     = 8,
   parameter int STEP      = 5,
   parameter int START_UP  = 50,
   parameter int LIM_MIN   = 10,
   parameter int LIM_MAX   = 330,
   parameter bit HAS_CLAMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ico_en,
   input  logic             src_dcp,
   input  logic             force_set,
   input  logic             src_attach,
   input  logic             hiz_bit,
   input  logic             ilim_wr,
   input  logic             vlim_wr,
   input  logic             bus_ovp,
   input  logic [LIM_W-1:0] prog_lim,
   input  logic [LIM_W-1:0] ext_lim,
   input  logic             ext_lim_en,
   input  logic             batt_above_min,
   input  logic             vreg_active,
   input  logic [CNT_W-1:0] settle_cnt,
   input  logic             flag_rd,
   output logic [LIM_W-1:0] eff_lim,
   output logic [1:0]       ico_status,
   output logic             ico_done
);
   logic             restart;
   logic             done_now;
   ico_st_e          state;
   logic [LIM_W-1:0] cur_lim;

   ico_trigger i_trig (
      .clk(clk), .rst_n(rst_n), .en(ico_en), .src_dcp(src_dcp),
      .force_set(force_set), .src_attach(src_attach), .hiz_bit(hiz_bit),
      .ilim_wr(ilim_wr), .vlim_wr(vlim_wr), .bus_ovp(bus_ovp),
      .restart(restart)
   );

   ico_search #(
      .LIM_W(LIM_W), .CNT_W(CNT_W), .STEP(STEP), .START_UP(START_UP),
      .LIM_MIN(LIM_MIN), .LIM_MAX(LIM_MAX)
   ) i_srch (
      .clk(clk), .rst_n(rst_n), .en(ico_en), .restart(restart),
      .batt_above(batt_above_min), .vreg(vreg_active), .prog_lim(prog_lim),
      .settle(settle_cnt), .state(state), .cur_lim(cur_lim), .done_now(done_now)
   );

   ico_limit_out #(.LIM_W(LIM_W), .HAS_CLAMP(HAS_CLAMP)) i_out (
      .use_cur(ico_en && state != ST_IDLE), .cur_lim(cur_lim),
      .prog_lim(prog_lim), .ext_lim(ext_lim), .ext_en(ext_lim_en),
      .eff_lim(eff_lim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ico_done <= 1'b0;
      else if (done_now) ico_done <= 1'b1;
      else if (flag_rd)  ico_done <= 1'b0;
   end

   assign ico_status = state;

   // R3: the status never takes the unused code
   p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ico_status != 2'b11);
   // R13: disabling returns the status to idle
   p_disable_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !ico_en |=> ico_status == 2'b00);
   // R8: the flag rises with the found status
   p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ico_status == 2'b10 && $past(ico_status) != 2'b10) |-> ico_done);
   // R10: a restart event always leads to searching
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> ico_status == 2'b01);
endmodule

// File: tb/test_ico_ctrl.sv
`timescale 1ns/1ps
module test_ico_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ico_en = 0, src_dcp = 0, force_set = 0, src_attach = 0, hiz_bit = 0;
   logic       ilim_wr = 0, vlim_wr = 0, bus_ovp = 0, ext_lim_en = 0;
   logic       batt_above_min = 0, flag_rd = 0;
   logic [8:0] prog_lim = 9'd200, ext_lim = 9'd500;
   logic [7:0] settle_cnt = 8'd3;
   logic [8:0] eff_lim;
   logic [1:0] ico_status;
   logic       ico_done;
   logic       vreg_active;
   logic       plant_on = 1'b0, vreg_force = 1'b0;
   int         cap = 0;
   int         n_cmp = 0, n_bad = 0, wd = 0;

   always #10 clk = ~clk;

   assign vreg_active = plant_on ? (int'(eff_lim) > cap) : vreg_force;

   ico_ctrl i_ico_ctrl (
      .clk(clk), .rst_n(rst_n), .ico_en(ico_en), .src_dcp(src_dcp),
      .force_set(force_set), .src_attach(src_attach), .hiz_bit(hiz_bit),
      .ilim_wr(ilim_wr), .vlim_wr(vlim_wr), .bus_ovp(bus_ovp),
      .prog_lim(prog_lim), .ext_lim(ext_lim), .ext_lim_en(ext_lim_en),
      .batt_above_min(batt_above_min), .vreg_active(vreg_active),
      .settle_cnt(settle_cnt), .flag_rd(flag_rd), .eff_lim(eff_lim),
      .ico_status(ico_status), .ico_done(ico_done)
   );

   // behavioural reference: 0 idle, 1 searching, 2 found
   int m_st, m_cur, m_wait, m_flag, m_hiz;
   bit m_up;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cur = 0; m_wait = 0; m_flag = 0; m_hiz = 0; m_up = 0;
      end else begin
         bit ev, fin;
         ev  = src_dcp | force_set | src_attach | (int'(hiz_bit) != m_hiz) |
               ilim_wr | vlim_wr | bus_ovp;
         fin = 0;
         m_hiz = hiz_bit;
         if (!ico_en) m_st = 0;
         else if (ev) begin
            m_st = 1; m_up = batt_above_min;
            m_cur = batt_above_min ? 50 : int'(prog_lim);
            m_wait = settle_cnt;
         end else if (m_st == 1) begin
            if (m_wait > 0) m_wait--;
            else if (m_up) begin
               if (vreg_active) begin
                  if (m_cur > 50) m_cur -= 5;
                  fin = 1;
               end else if (m_cur + 5 > 330) fin = 1;
               else begin m_cur += 5; m_wait = settle_cnt; end
            end else begin
               if (!vreg_active) fin = 1;
               else if (m_cur - 5 < 10) fin = 1;
               else begin m_cur -= 5; m_wait = settle_cnt; end
            end
            if (fin) m_st = 2;
         end
         if (fin) m_flag = 1;
         else if (flag_rd) m_flag = 0;
      end
   end

   function automatic int model_eff();
      int b;
      b = (ico_en && m_st != 0) ? m_cur : int'(prog_lim);
      if (ext_lim_en && int'(ext_lim) < b) b = ext_lim;
      return b;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (rst_n) begin
      chk("R11/R12 eff_lim", int'(eff_lim), model_eff());
      chk("R3/R8 ico_status", int'(ico_status), m_st);
      chk("R9 ico_done", int'(ico_done), m_flag);
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic step(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wait_found();
      for (int i = 0; i < 3000 && ico_status != 2'b10; i++) step(1);
   endtask

   initial begin
      step(2);
      @(negedge clk);
      chk("R1 status after reset", int'(ico_status), 0);
      chk("R1 eff after reset", int'(eff_lim), 200);
      rst_n = 1'b1;
      step(2);
      chk("R1 flag after reset", int'(ico_done), 0);

      // R2: triggers while disabled
      force_set = 1; src_dcp = 1; step(1); force_set = 0; src_dcp = 0;
      step(1);
      chk("R2 status disabled", int'(ico_status), 0);
      chk("R2 eff disabled", int'(eff_lim), 200);

      // R3 R7 R4: upward search, settle timing
      ico_en = 1; batt_above_min = 1; plant_on = 1; cap = 120;
      step(1);
      src_dcp = 1; step(1); src_dcp = 0;
      chk("R3 status searching", int'(ico_status), 1);
      chk("R4 start code", int'(eff_lim), 50);
      step(3);
      chk("R7 held through settle", int'(eff_lim), 50);
      step(1);
      chk("R7 step after settle", int'(eff_lim), 55);
      wait_found();
      chk("R4 up result", int'(eff_lim), 120);
      chk("R8 flag set", int'(ico_done), 1);
      cap = 0; step(10);
      chk("R8 holds", int'(eff_lim), 120);
      flag_rd = 1; step(1); flag_rd = 0;
      chk("R9 flag cleared", int'(ico_done), 0);

      // R12: clamp
      ext_lim = 9'd100; ext_lim_en = 1; step(1);
      chk("R12 clamp on", int'(eff_lim), 100);
      ext_lim_en = 0; step(1);
      chk("R12 clamp off", int'(eff_lim), 120);

      // R4 edge: regulation already at start
      cap = 40; force_set = 1; step(1); force_set = 0;
      wait_found();
      chk("R4 stays at start", int'(eff_lim), 50);

      // R5: ceiling
      cap = 1000; settle_cnt = 8'd0; src_attach = 1; step(1); src_attach = 0;
      wait_found();
      chk("R5 ceiling", int'(eff_lim), 330);

      // R6: downward search
      settle_cnt = 8'd2; batt_above_min = 0; cap = 130;
      ilim_wr = 1; step(1); ilim_wr = 0;
      chk("R6 down start", int'(eff_lim), 200);
      wait_found();
      chk("R6 down result", int'(eff_lim), 130);

      // R6 floor
      prog_lim = 9'd20; cap = 0;
      vlim_wr = 1; step(1); vlim_wr = 0;
      wait_found();
      chk("R6 floor", int'(eff_lim), 10);

      // R10: each restart event
      prog_lim = 9'd150; cap = 140; settle_cnt = 8'd4;
      for (int e = 0; e < 6; e++) begin
         case (e)
            0: src_attach = 1; 1: ilim_wr = 1; 2: vlim_wr = 1;
            3: bus_ovp = 1; 4: force_set = 1; default: hiz_bit = ~hiz_bit;
         endcase
         step(1);
         src_attach = 0; ilim_wr = 0; vlim_wr = 0; bus_ovp = 0; force_set = 0;
         chk("R10 restart status", int'(ico_status), 1);
         wait_found();
         chk("R10 result", int'(eff_lim), 140);
      end

      // R13: disable mid-search, R11 falls back to prog
      batt_above_min = 1; cap = 300;
      force_set = 1; step(1); force_set = 0;
      step(9);
      ico_en = 0; step(1);
      chk("R13 status idle", int'(ico_status), 0);
      chk("R11 eff prog when off", int'(eff_lim), 150);
      step(5);
      summary();
   end
endmodule